// File: doc/BRIEF.md
# Sector Unprotect Sequencer

This block is a host-side bus master that walks a 35-sector flash device through its in-system unprotect procedure. After a start pulse it applies the high-voltage level to the device reset pin through a control output, waits a setup interval, and then repeats an unlock pulse followed by a per-sector verify loop. The loop checks sectors in ascending order. It retries the unlock pulse whenever a sector still reads back as protected. It gives up after a fixed number of attempts.

Every device access goes over a small strobe-and-acknowledge bus. The sequencer drives an address, write data, and either a write or a read strobe. It holds that request until the bus side acknowledges it, and read data is taken on the acknowledge cycle. All waits are counted in clock cycles and set by parameters, so the same RTL serves a real clock and a shortened test run. The result is reported on two sticky flags, done and fail.

Top module: `sector_unlock_seq`

## Requirements
- R1: A start pulse seen while idle, done or failed raises `hv_en`, sets the attempt count to 1 and the sector index to 0, and clears `done` and `fail`. No bus access begins until at least `SETUP_CYC` cycles after `hv_en` rises.
- R2: An unlock pulse is two writes of data 0x60. The first goes to address 0. The second goes to address 0x00042 (address bits 6 and 1 set, bit 0 clear). After that, no bus access begins for at least `PULSE_CYC` cycles.
- R3: A verify of sector s writes 0x40 to address (s << 12) | 0x042, with s in address bits 19:12. It then reads from that same address. Sectors are verified in order 0, 1, 2 and so on, and every read occurs with `hv_en` high.
- R4: A verify read of 0x00 is a pass. A pass on sector 34 ends the loop. A pass on any other sector moves on to verify the next sector with no unlock pulse in between.
- R5: A verify read other than 0x00 is a miss. If the attempt count equals `MAX_TRIES`, the run fails. Otherwise the count increments and an unlock pulse repeats before the same sector is verified again. The count is not reset between sectors, so a run issues max(1, highest pulses needed by any sector) unlock pulses in total.
- R6: On success, `hv_en` falls first. Then one write of `RESET_CMD` (default 0xF0) to address 0 is made with `hv_en` low, and after that `done` rises.
- R7: On failure, `hv_en` falls, `fail` rises, and no reset-command write is made.
- R8: A write or read strobe stays high, with address and write data unchanged, until the cycle in which `bus_ack` is seen. Write and read strobes are never high together.
- R9: `done` and `fail` stay set until the next accepted start. A start pulse during a run is ignored.
- R10: While `rst_n` is low, `hv_en`, `done`, `fail`, `bus_wr` and `bus_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a procedure (single-cycle pulse) |
| bus_addr | output | ADDR_W | Device address of the current access |
| bus_wdata | output | DATA_W | Write data of the current access |
| bus_wr | output | 1 | Write strobe, held until acknowledged |
| bus_rd | output | 1 | Read strobe, held until acknowledged |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access acknowledge |
| hv_en | output | 1 | Apply the high-voltage level to the device reset pin |
| done | output | 1 | Procedure finished, all sectors unprotected (sticky) |
| fail | output | 1 | Attempt limit reached (sticky) |

## Verification
A wrong sector index shows up at the very next verify write, because address bits 19:12 no longer follow the ascending order. A wrong attempt count stays hidden until the run ends, where it shows as a total of unlock pulses and verify reads that differs from the arithmetic expectation. The same goes for an attempt count that is reset between sectors. Timer faults appear within one interval, as a gap that is too short between `hv_en` rising or the second 0x60 write and the next access. A fault in the exit path shows within a few cycles of the last pass, as a reset-command write made while `hv_en` is high, or a missing one.

// File: rtl/usq_pkg.sv
package usq_pkg;

   localparam logic [7:0]  CMD_UNLOCK  = 8'h60;
   localparam logic [7:0]  CMD_VERIFY  = 8'h40;
   localparam logic [11:0] TAG_ADDR_LO = 12'h042;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_PULSE_A,
      ST_PULSE_B,
      ST_PULSE_WAIT,
      ST_VFY_WR,
      ST_VFY_RD,
      ST_EXIT_WR,
      ST_DONE,
      ST_FAIL
   } seq_state_t;

endpackage

// File: rtl/usq_delay_timer.sv
module usq_delay_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] value,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= value;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/usq_bus_master.sv
module usq_bus_master #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              issue_wr,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic [DATA_W-1:0] issue_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_wr,
   output logic              bus_rd,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   output logic              op_done,
   output logic              rd_zero
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_addr  <= '0;
         bus_wdata <= '0;
         bus_wr    <= 1'b0;
         bus_rd    <= 1'b0;
         op_done   <= 1'b0;
         rd_zero   <= 1'b0;
      end else begin
         op_done <= 1'b0;
         if (issue) begin
            bus_addr  <= issue_addr;
            bus_wdata <= issue_wr ? issue_data : '0;
            bus_wr    <= issue_wr;
            bus_rd    <= !issue_wr;
         end else if ((bus_wr || bus_rd) && bus_ack) begin
            bus_wr  <= 1'b0;
            bus_rd  <= 1'b0;
            op_done <= 1'b1;
            if (bus_rd) begin
               rd_zero <= (bus_rdata == '0);
            end
         end
      end
   end

endmodule

// File: rtl/usq_fsm.sv
module usq_fsm
   import usq_pkg::*;
#(
   parameter int         ADDR_W      = 20,
   parameter int         NUM_SECTORS = 35,
   parameter int         SECT_LSB    = 12,
   parameter int         MAX_TRIES   = 1000,
   parameter int         SETUP_CYC   = 50,
   parameter int         PULSE_CYC   = 750000,
   parameter logic [7:0] RESET_CMD   = 8'hF0,
   parameter int         CNT_W       = 20,
   parameter int         TRY_W       = 10,
   parameter int         SECT_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_done,
   input  logic              rd_zero,
   input  logic              tmr_zero,
   output logic              issue,
   output logic              issue_wr,
   output logic [ADDR_W-1:0] issue_addr,
   output logic [7:0]        issue_cmd,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_value,
   output logic              hv_en,
   output logic              done,
   output logic              fail
);

   localparam logic [SECT_W-1:0] LAST_SECT = SECT_W'(NUM_SECTORS - 1);
   localparam logic [TRY_W-1:0]  TRY_LIMIT = TRY_W'(MAX_TRIES);

   seq_state_t        state_q;
   logic              armed_q;
   logic [SECT_W-1:0] sect_q;
   logic [TRY_W-1:0]  tries_q;
   logic              is_wait;
   logic              is_bus;
   logic [ADDR_W-1:0] vfy_addr;

   assign is_wait  = (state_q == ST_SETUP) || (state_q == ST_PULSE_WAIT);
   assign is_bus   = (state_q == ST_PULSE_A) || (state_q == ST_PULSE_B) ||
                     (state_q == ST_VFY_WR)  || (state_q == ST_VFY_RD)  ||
                     (state_q == ST_EXIT_WR);
   assign vfy_addr = (ADDR_W'(sect_q) << SECT_LSB) | ADDR_W'(TAG_ADDR_LO);

   assign tmr_load  = is_wait && !armed_q;
   assign tmr_value = (state_q == ST_SETUP) ? CNT_W'(SETUP_CYC) : CNT_W'(PULSE_CYC);
   assign issue     = is_bus && !armed_q;

   always_comb begin
      issue_wr   = 1'b1;
      issue_addr = '0;
      issue_cmd  = '0;
      unique case (state_q)
         ST_PULSE_A: begin
            issue_cmd = CMD_UNLOCK;
         end
         ST_PULSE_B: begin
            issue_addr = ADDR_W'(TAG_ADDR_LO);
            issue_cmd  = CMD_UNLOCK;
         end
         ST_VFY_WR: begin
            issue_addr = vfy_addr;
            issue_cmd  = CMD_VERIFY;
         end
         ST_VFY_RD: begin
            issue_wr   = 1'b0;
            issue_addr = vfy_addr;
         end
         ST_EXIT_WR: begin
            issue_cmd = RESET_CMD;
         end
         default: begin
            issue_wr = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         armed_q <= 1'b0;
         sect_q  <= '0;
         tries_q <= '0;
         hv_en   <= 1'b0;
         done    <= 1'b0;
         fail    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
               if (start) begin
                  state_q <= ST_SETUP;
                  armed_q <= 1'b0;
                  sect_q  <= '0;
                  tries_q <= TRY_W'(1);
                  hv_en   <= 1'b1;
                  done    <= 1'b0;
                  fail    <= 1'b0;
               end
            end
            ST_SETUP, ST_PULSE_WAIT: begin
               if (!armed_q) begin
                  armed_q <= 1'b1;
               end else if (tmr_zero) begin
                  armed_q <= 1'b0;
                  state_q <= (state_q == ST_SETUP) ? ST_PULSE_A : ST_VFY_WR;
               end
            end
            default: begin
               if (!armed_q) begin
                  armed_q <= 1'b1;
               end else if (op_done) begin
                  armed_q <= 1'b0;
                  unique case (state_q)
                     ST_PULSE_A: state_q <= ST_PULSE_B;
                     ST_PULSE_B: state_q <= ST_PULSE_WAIT;
                     ST_VFY_WR:  state_q <= ST_VFY_RD;
                     ST_VFY_RD: begin
                        if (rd_zero) begin
                           if (sect_q == LAST_SECT) begin
                              hv_en   <= 1'b0;
                              state_q <= ST_EXIT_WR;
                           end else begin
                              sect_q  <= sect_q + 1'b1;
                              state_q <= ST_VFY_WR;
                           end
                        end else if (tries_q == TRY_LIMIT) begin
                           hv_en   <= 1'b0;
                           fail    <= 1'b1;
                           state_q <= ST_FAIL;
                        end else begin
                           tries_q <= tries_q + 1'b1;
                           state_q <= ST_PULSE_A;
                        end
                     end
                     ST_EXIT_WR: begin
                        done    <= 1'b1;
                        state_q <= ST_DONE;
                     end
                     default: state_q <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/sector_unlock_seq.sv
module sector_unlock_seq #(
   parameter int         ADDR_W      = 20,
   parameter int         DATA_W      = 8,
   parameter int         NUM_SECTORS = 35,
   parameter int         SECT_LSB    = 12,
   parameter int         MAX_TRIES   = 1000,
   parameter int         SETUP_CYC   = 50,
   parameter int         PULSE_CYC   = 750000,
   parameter logic [7:0] RESET_CMD   = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_wr,
   output logic              bus_rd,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   output logic              hv_en,
   output logic              done,
   output logic              fail
);

   localparam int LONGEST = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam int TRY_W   = $clog2(MAX_TRIES + 1);
   localparam int SECT_W  = $clog2(NUM_SECTORS);

   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end
   if (NUM_SECTORS < 2) begin : g_bad_sect
      $error("NUM_SECTORS must be at least 2");
   end
   if (SECT_LSB < 7 || SECT_LSB + SECT_W > ADDR_W) begin : g_bad_field
      $error("sector field does not fit the address");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("MAX_TRIES must be at least 1");
   end

   logic              issue;
   logic              issue_wr;
   logic [ADDR_W-1:0] issue_addr;
   logic [7:0]        issue_cmd;
   logic [DATA_W-1:0] issue_data;
   logic              op_done;
   logic              rd_zero;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_value;
   logic              tmr_zero;

   if (DATA_W == 8) begin : g_data_byte
      assign issue_data = issue_cmd;
   end else begin : g_data_wide
      assign issue_data = {{(DATA_W-8){1'b0}}, issue_cmd};
   end

   usq_fsm #(
      .ADDR_W      (ADDR_W),
      .NUM_SECTORS (NUM_SECTORS),
      .SECT_LSB    (SECT_LSB),
      .MAX_TRIES   (MAX_TRIES),
      .SETUP_CYC   (SETUP_CYC),
      .PULSE_CYC   (PULSE_CYC),
      .RESET_CMD   (RESET_CMD),
      .CNT_W       (CNT_W),
      .TRY_W       (TRY_W),
      .SECT_W      (SECT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op_done    (op_done),
      .rd_zero    (rd_zero),
      .tmr_zero   (tmr_zero),
      .issue      (issue),
      .issue_wr   (issue_wr),
      .issue_addr (issue_addr),
      .issue_cmd  (issue_cmd),
      .tmr_load   (tmr_load),
      .tmr_value  (tmr_value),
      .hv_en      (hv_en),
      .done       (done),
      .fail       (fail)
   );

   usq_delay_timer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .value (tmr_value),
      .zero  (tmr_zero)
   );

   usq_bus_master #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_wr   (issue_wr),
      .issue_addr (issue_addr),
      .issue_data (issue_data),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_rdata  (bus_rdata),
      .bus_ack    (bus_ack),
      .op_done    (op_done),
      .rd_zero    (rd_zero)
   );

endmodule

// File: rtl/usq_checker.sv
module usq_checker #(
   parameter int         ADDR_W    = 20,
   parameter int         DATA_W    = 8,
   parameter logic [7:0] RESET_CMD = 8'hF0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              bus_ack,
   input logic              hv_en,
   input logic              done,
   input logic              fail
);

   assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

   assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_addr)));

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   assert_read_hv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> hv_en);

   assert_exit_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hv_en) |-> (bus_wdata == DATA_W'(RESET_CMD)));

   assert_done_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!hv_en && !fail && !bus_wr && !bus_rd));

   assert_fail_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (!hv_en && !bus_wr && !bus_rd));

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> fail);

   assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hv_en) |-> (!done && !fail));

endmodule

bind sector_unlock_seq usq_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .RESET_CMD (RESET_CMD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_ack   (bus_ack),
   .hv_en     (hv_en),
   .done      (done),
   .fail      (fail)
);

// File: tb/sim_sector_unlock_seq.sv
module sim_sector_unlock_seq;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 20;
   localparam int DATA_W     = 8;
   localparam int NSEC       = 35;
   localparam int MAXT       = 4;
   localparam int SETUP      = 6;
   localparam int PULSE      = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic              bus_wr;
   logic              bus_rd;
   logic [DATA_W-1:0] bus_rdata = '0;
   logic              bus_ack = 1'b0;
   logic              hv_en;
   logic              done;
   logic              fail;

   int n_checks = 0;
   int n_errs   = 0;
   int need [NSEC];

   int cyc = 0;
   int hv_rise = 0;
   bit hv_prev = 0;
   bit first_acc = 0;
   bit prev_a = 0;
   bit vfy_pend = 0;
   bit pulse_pend = 0;
   int pulse_cyc = 0;
   logic [ADDR_W-1:0] vfy_addr = '0;
   int n_pulse = 0;
   int n_read = 0;
   int n_reset = 0;
   int exp_sect = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sector_unlock_seq #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .NUM_SECTORS (NSEC),
      .SECT_LSB    (12),
      .MAX_TRIES   (MAXT),
      .SETUP_CYC   (SETUP),
      .PULSE_CYC   (PULSE),
      .RESET_CMD   (8'hF0)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .bus_ack   (bus_ack),
      .hv_en     (hv_en),
      .done      (done),
      .fail      (fail)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Responsive device stub plus protocol checks, all at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (hv_en && !hv_prev) hv_rise = cyc;
      hv_prev = hv_en;
      if (cyc > 190000) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
         $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
      if (bus_ack) begin
         bus_ack = 1'b0;
      end else if (bus_wr || bus_rd) begin
         bus_ack = 1'b1;
         if (first_acc) begin
            first_acc = 0;
            chk((cyc - hv_rise) >= SETUP && (cyc - hv_rise) <= SETUP + 6,
                "R1 setup gap", cyc - hv_rise, SETUP);
         end
         if (pulse_pend) begin
            pulse_pend = 0;
            chk((cyc - pulse_cyc) >= PULSE && (cyc - pulse_cyc) <= PULSE + 8,
                "R2 pulse gap", cyc - pulse_cyc, PULSE);
         end
         if (bus_wr) begin
            if (bus_wdata == 8'h60 && bus_addr == 20'h0) begin
               chk(hv_en && !prev_a, "R2 first unlock write", int'(hv_en), 1);
               prev_a = 1;
            end else if (bus_wdata == 8'h60 && bus_addr == 20'h00042) begin
               chk(prev_a, "R2 second unlock write order", int'(prev_a), 1);
               prev_a = 0;
               n_pulse++;
               pulse_pend = 1;
               pulse_cyc = cyc;
            end else if (bus_wdata == 8'h40) begin
               chk(bus_addr == ((20'(exp_sect) << 12) | 20'h042) && !prev_a,
                   "R3 verify address", int'(bus_addr), (exp_sect << 12) | 'h42);
               vfy_addr = bus_addr;
               vfy_pend = 1;
            end else if (bus_wdata == 8'hF0) begin
               chk(!hv_en && bus_addr == 20'h0, "R6 reset command with hv low",
                   int'(hv_en), 0);
               n_reset++;
            end else begin
               chk(0, "R2 unexpected write data", int'(bus_wdata), 'h60);
            end
         end else begin
            chk(vfy_pend && bus_addr == vfy_addr && hv_en, "R3 read follows verify write",
                int'(bus_addr), int'(vfy_addr));
            vfy_pend = 0;
            n_read++;
            if (exp_sect < NSEC && n_pulse < need[exp_sect]) begin
               bus_rdata = 8'h01;
            end else begin
               bus_rdata = 8'h00;
               exp_sect++;
            end
         end
      end
   end

   task automatic run_case(input string name, input bit mid_start);
      int first_bad = -1;
      int maxneed = 0;
      int e_pulse, e_read, e_reset;
      bit e_done, e_fail;
      int t = 0;
      for (int s = 0; s < NSEC; s++) begin
         if (need[s] > maxneed) maxneed = need[s];
         if (first_bad < 0 && need[s] > MAXT) first_bad = s;
      end
      if (first_bad >= 0) begin
         e_fail = 1; e_done = 0; e_pulse = MAXT; e_read = first_bad + MAXT; e_reset = 0;
      end else begin
         e_fail = 0; e_done = 1;
         e_pulse = (maxneed < 1) ? 1 : maxneed;
         e_read = NSEC + e_pulse - 1; e_reset = 1;
      end
      first_acc = 1; prev_a = 0; vfy_pend = 0; pulse_pend = 0;
      n_pulse = 0; n_read = 0; n_reset = 0; exp_sect = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (mid_start) begin
         repeat (40) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      while (!(done || fail) && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(t < 20000, {"R9 run ends ", name}, t, 20000);
      chk(done == e_done, {"R4 done ", name}, int'(done), int'(e_done));
      chk(fail == e_fail, {"R7 fail ", name}, int'(fail), int'(e_fail));
      chk(n_pulse == e_pulse, {"R5 pulse count ", name}, n_pulse, e_pulse);
      chk(n_read == e_read, {"R4 read count ", name}, n_read, e_read);
      chk(n_reset == e_reset, {"R6 reset cmd count ", name}, n_reset, e_reset);
      chk(!hv_en, {"R7 hv off at end ", name}, int'(hv_en), 0);
      repeat (5) @(negedge clk);
      chk(done == e_done && fail == e_fail && !bus_wr && !bus_rd,
          {"R9 flags sticky ", name}, int'({done, fail}), int'({e_done, e_fail}));
   endtask

   task automatic set_all(input int v);
      for (int s = 0; s < NSEC; s++) need[s] = v;
   endtask

   initial begin
      set_all(0);
      repeat (3) @(negedge clk);
      chk(!hv_en && !done && !fail && !bus_wr && !bus_rd, "R10 reset outputs",
          int'({hv_en, done, fail, bus_wr, bus_rd}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!hv_en && !done && !fail, "R10 idle before start",
          int'({hv_en, done, fail}), 0);

      set_all(0);
      run_case("all clear", 0);
      set_all(1);
      run_case("all one pulse", 0);

      // sweep: one sector needing v pulses, v across the limit
      foreach (need[k]) begin
         if (k == 0 || k == 1 || k == 17 || k == 33 || k == 34) begin
            for (int v = 0; v <= MAXT + 1; v++) begin
               set_all(0);
               need[k] = v;
               run_case($sformatf("sector %0d needs %0d", k, v), 0);
            end
         end
      end

      // staggered needs, peak exactly at the limit, with an ignored start
      for (int s = 0; s < NSEC; s++) need[s] = s % (MAXT + 1);
      run_case("staggered, mid-run start", 1);

      // failing run followed by a clean run: flags cleared by the new start
      set_all(0);
      need[20] = MAXT + 3;
      run_case("fail then", 0);
      set_all(0);
      run_case("recovery", 0);

      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule